// File: doc/BRIEF.md
# Two-Wire Address Slave with High-Speed Mode Entry

This block is the address front end of a two-wire (I2C-style) bus slave. It oversamples the SCL and SDA lines with the system clock, passes both through a synchroniser, and detects START, repeated START and STOP conditions from the resynchronised levels. After every START or repeated START it shifts in one byte, most significant bit first, and compares its upper seven bits with a fixed slave address set by a parameter.

On a match it pulls SDA low for the ninth (acknowledge) clock, latches the direction bit and pulses a one-cycle strobe when that clock ends. A byte of the form 0000_1xxx is taken as the high-speed master code. The block answers it with a deliberate not-acknowledge and then raises a sticky high-speed mode flag. That flag survives repeated STARTs and is cleared only by a STOP. Any other byte is ignored, and so is the rest of the bus until the next START. Data bytes after the address are handled by logic downstream of this block.

Top module: `twi_hs_slave`

## Requirements
- R1: After reset, sda_pull_o, addr_hit_o, rd_wr_o and hs_mode_o are all 0.
- R2: A START is SDA falling while SCL is high. After it, the block samples SDA on each of the next eight SCL rising edges and assembles the byte MSB first. A byte whose bit order is reversed relative to the slave address is not accepted.
- R3: When bits 7..1 of the captured byte equal the SLV_ADDR parameter, sda_pull_o rises after the SCL falling edge that ends the eighth bit. It stays high for the whole ninth SCL period and drops after the SCL falling edge that ends that period.
- R4: On an address match, rd_wr_o takes bit 0 of the byte (0 = master writes, 1 = master reads) and holds that value until the next match.
- R5: addr_hit_o is high for exactly one clock cycle per matched address, in the cycle where sda_pull_o drops, and never pulses for a byte that does not match.
- R6: A byte whose bits 7..3 are 00001 (bits 2..0 are don't-care) gets no acknowledge: sda_pull_o stays 0 through the ninth clock. hs_mode_o is 1 after the SCL falling edge that ends the ninth clock.
- R7: While hs_mode_o is 1, a repeated START followed by a matching address is acknowledged, and its direction is reported, exactly as in R3 to R5.
- R8: hs_mode_o stays 1 across repeated STARTs. A STOP (SDA rising while SCL is high) clears it to 0.
- R9: A byte that neither matches nor is the master code gets no acknowledge. Later bits on the bus, even bits that form a matching address, are ignored until the next START or repeated START.
- R10: With SLV_ADDR set to 7'b0110101, the byte 0x6A is acknowledged. With the default 7'b0110100 it is not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, oversampling the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_o | output | 1 | 1 = drive SDA low (acknowledge) |
| addr_hit_o | output | 1 | One-cycle strobe when an acknowledged address completes |
| rd_wr_o | output | 1 | Direction of the last matched address, 1 = read |
| hs_mode_o | output | 1 | 1 = high-speed mode, 0 = fast/standard mode |

## Verification
The hardest state to reach from the ports is high-speed mode followed by a repeated START and a new address. The mode flag must stay set through that second condition, while the address logic starts over as if fresh. The bench reaches it by sending the master code, completing its not-acknowledged ninth clock, then raising SDA and SCL and pulling SDA low without a STOP. A second hard case is a rejected byte followed by a valid address pattern clocked without a START. That case shows the ignore state really holds until a START arrives.

// File: rtl/twi_pkg.sv
package twi_pkg;
  localparam int ADDR_W = 7;
  localparam int BYTE_W = 8;
  localparam int PFX_W  = 5;
  localparam logic [PFX_W-1:0] HS_PREFIX = 5'b00001;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_HSNACK,
    ST_SKIP
  } twi_state_e;
endpackage

// File: rtl/twi_sync.sv
module twi_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    // bus idles high; reset to 1 avoids a false edge
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain <= '1;
      else         chain <= {chain[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/twi_cond.sv
module twi_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  assign start_o    = scl_s_i & scl_q & sda_q & ~sda_s_i;
  assign stop_o     = scl_s_i & scl_q & ~sda_q & sda_s_i;
  assign scl_rise_o = scl_s_i & ~scl_q;
  assign scl_fall_o = ~scl_s_i & scl_q;
endmodule

// File: rtl/twi_addr_fsm.sv
module twi_addr_fsm
  import twi_pkg::*;
#(
  parameter logic [ADDR_W-1:0] SLV_ADDR = 7'b0110100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sda_s_i,
  input  logic start_i,
  input  logic stop_i,
  input  logic scl_rise_i,
  input  logic scl_fall_i,
  output logic sda_pull_o,
  output logic addr_hit_o,
  output logic rd_wr_o,
  output logic hs_mode_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  twi_state_e        state;
  logic [BYTE_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;
  logic              ninth_seen;
  logic              addr_match, hs_code;

  assign addr_match = (shreg[BYTE_W-1:1] == SLV_ADDR);
  assign hs_code    = (shreg[BYTE_W-1:BYTE_W-PFX_W] == HS_PREFIX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state      <= ST_IDLE;
      shreg      <= '0;
      cnt        <= '0;
      ninth_seen <= 1'b0;
      sda_pull_o <= 1'b0;
      addr_hit_o <= 1'b0;
      rd_wr_o    <= 1'b0;
      hs_mode_o  <= 1'b0;
    end else begin
      addr_hit_o <= 1'b0;
      if (stop_i) begin
        state      <= ST_IDLE;
        sda_pull_o <= 1'b0;
        hs_mode_o  <= 1'b0;
      end else if (start_i) begin
        state      <= ST_ADDR;
        cnt        <= '0;
        sda_pull_o <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR: begin
            if (scl_rise_i) begin
              shreg <= {shreg[BYTE_W-2:0], sda_s_i};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall_i && cnt == LAST_BIT) begin
              cnt        <= '0;
              ninth_seen <= 1'b0;
              if (addr_match) begin
                sda_pull_o <= 1'b1;
                rd_wr_o    <= shreg[0];
                state      <= ST_ACK;
              end else if (hs_code) begin
                state <= ST_HSNACK;
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          ST_ACK: begin
            if (scl_rise_i) begin
              ninth_seen <= 1'b1;
            end else if (scl_fall_i && ninth_seen) begin
              sda_pull_o <= 1'b0;
              addr_hit_o <= 1'b1;
              state      <= ST_SKIP;
            end
          end
          ST_HSNACK: begin
            if (scl_rise_i) begin
              ninth_seen <= 1'b1;
            end else if (scl_fall_i && ninth_seen) begin
              hs_mode_o <= 1'b1;
              state     <= ST_SKIP;
            end
          end
          ST_IDLE, ST_SKIP: ;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R5: strobe lasts one cycle
  p_hit_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_hit_o |=> !addr_hit_o);

  // R3: strobe coincides with the release of the pull-down
  p_hit_release_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_hit_o |-> (!sda_pull_o && $past(sda_pull_o)));

  // R3: pull-down held until an SCL fall or a bus condition
  p_pull_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_pull_o && !scl_fall_i && !start_i && !stop_i) |=> sda_pull_o);

  // R6: master code is never acknowledged
  p_hs_nack_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_HSNACK) |-> !sda_pull_o);

  // R6: mode flag rises only out of the master-code ninth clock
  p_hs_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_mode_o) |-> $past(state == ST_HSNACK));

  // R8: STOP clears the mode flag
  p_hs_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !hs_mode_o);
endmodule

// File: rtl/twi_hs_slave.sv
module twi_hs_slave
  import twi_pkg::*;
#(
  parameter logic [ADDR_W-1:0] SLV_ADDR    = 7'b0110100,
  parameter int                SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_pull_o,
  output logic addr_hit_o,
  output logic rd_wr_o,
  output logic hs_mode_o
);
  logic [1:0] line_s;
  logic       start, stop, scl_rise, scl_fall;

  twi_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({scl_i, sda_i}),
    .q_o    (line_s)
  );

  twi_cond u_cond (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_s_i    (line_s[1]),
    .sda_s_i    (line_s[0]),
    .start_o    (start),
    .stop_o     (stop),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall)
  );

  twi_addr_fsm #(.SLV_ADDR(SLV_ADDR)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sda_s_i    (line_s[0]),
    .start_i    (start),
    .stop_i     (stop),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .sda_pull_o (sda_pull_o),
    .addr_hit_o (addr_hit_o),
    .rd_wr_o    (rd_wr_o),
    .hs_mode_o  (hs_mode_o)
  );
endmodule

// File: tb/twi_hs_slave_test.sv
module twi_hs_slave_test;
  localparam int H = 8;
  localparam int NV = 9;
  // {byte[7:0], ack, hit, rw, hs_after_ninth}
  localparam logic [11:0] VEC [NV] = '{
    12'h68C, 12'h69E, 12'h6A0, 12'h081, 12'h0F1,
    12'h000, 12'h180, 12'hE80, 12'h160
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic pull, hit, rw, hs;
  logic pull_a, hit_a, rw_a, hs_a;
  int checks = 0, failures = 0;
  int hit_cnt = 0, hit_cnt_a = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  twi_hs_slave uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_m & ~pull),
    .sda_pull_o(pull), .addr_hit_o(hit), .rd_wr_o(rw), .hs_mode_o(hs)
  );

  twi_hs_slave #(.SLV_ADDR(7'b0110101)) uut_alt (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_m & ~pull_a),
    .sda_pull_o(pull_a), .addr_hit_o(hit_a), .rd_wr_o(rw_a), .hs_mode_o(hs_a)
  );

  always @(negedge clk) begin
    if (hit)   hit_cnt++;
    if (hit_a) hit_cnt_a++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wclk(H);
    scl_m = 1'b1; wclk(H);
    sda_m = 1'b0; wclk(H);
    scl_m = 1'b0; wclk(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wclk(H);
    scl_m = 1'b1; wclk(H);
    sda_m = 1'b1; wclk(H);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wclk(H);
      scl_m = 1'b1; wclk(2 * H);
      scl_m = 1'b0; wclk(H);
    end
  endtask

  // ninth clock: returns pull levels seen mid-high and after the falling edge
  task automatic ninth(output logic ack, output logic ack_a,
                       output logic rel, output logic rel_a);
    sda_m = 1'b1; wclk(H);
    scl_m = 1'b1; wclk(H);
    @(negedge clk); ack = pull; ack_a = pull_a;
    wclk(H);
    scl_m = 1'b0; wclk(H);
    @(negedge clk); rel = pull; rel_a = pull_a;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic ack, ack_a, rel, rel_a;
    int h0, ha0;
    wclk(4);
    @(negedge clk);
    chk("R1 pull", int'(pull), 0);
    chk("R1 hit", int'(hit), 0);
    chk("R1 rw", int'(rw), 0);
    chk("R1 hs", int'(hs), 0);
    rst_n = 1'b1;
    wclk(4);

    // table walk: R2 R3 R4 R5 R6 R9
    for (int v = 0; v < NV; v++) begin
      logic [11:0] e;
      e = VEC[v];
      h0 = hit_cnt;
      bus_start();
      send_byte(e[11:4]);
      ninth(ack, ack_a, rel, rel_a);
      chk("R3/R6/R9 ack", int'(ack), int'(e[3]));
      chk("R3 release", int'(rel), 0);
      chk("R5 hit count", hit_cnt - h0, int'(e[2]));
      if (e[2]) chk("R4 rw", int'(rw), int'(e[1]));
      chk("R6 hs after ninth", int'(hs), int'(e[0]));
      bus_stop();
      wclk(H);
      @(negedge clk);
      chk("R8 hs after stop", int'(hs), 0);
    end

    // R7 R8: master code, repeated START, read address
    h0 = hit_cnt;
    bus_start();
    send_byte(8'h0A);
    ninth(ack, ack_a, rel, rel_a);
    chk("R6 nack", int'(ack), 0);
    chk("R6 hs set", int'(hs), 1);
    bus_start();
    wclk(2);
    @(negedge clk);
    chk("R8 hs across Sr", int'(hs), 1);
    send_byte(8'h69);
    ninth(ack, ack_a, rel, rel_a);
    chk("R7 ack in hs", int'(ack), 1);
    chk("R7 release", int'(rel), 0);
    chk("R7 hit", hit_cnt - h0, 1);
    chk("R7 rw", int'(rw), 1);
    chk("R7 hs kept", int'(hs), 1);
    bus_start();
    send_byte(8'h68);
    ninth(ack, ack_a, rel, rel_a);
    chk("R7 second ack", int'(ack), 1);
    chk("R4 rw write", int'(rw), 0);
    bus_stop();
    wclk(H);
    @(negedge clk);
    chk("R8 stop clears", int'(hs), 0);

    // R9: rejected byte, then matching bits without START
    h0 = hit_cnt;
    bus_start();
    send_byte(8'hE8);
    ninth(ack, ack_a, rel, rel_a);
    chk("R9 no ack", int'(ack), 0);
    send_byte(8'h68);
    ninth(ack, ack_a, rel, rel_a);
    chk("R9 ignored ack", int'(ack), 0);
    chk("R9 ignored hit", hit_cnt - h0, 0);
    bus_start();
    send_byte(8'h68);
    ninth(ack, ack_a, rel, rel_a);
    chk("R9 Sr re-arms", int'(ack), 1);
    bus_stop();

    // R10: alternate address parameter
    h0 = hit_cnt; ha0 = hit_cnt_a;
    bus_start();
    send_byte(8'h6B);
    ninth(ack, ack_a, rel, rel_a);
    chk("R10 alt ack", int'(ack_a), 1);
    chk("R10 default no ack", int'(ack), 0);
    chk("R10 alt release", int'(rel_a), 0);
    chk("R10 alt hit", hit_cnt_a - ha0, 1);
    chk("R10 alt rw", int'(rw_a), 1);
    chk("R10 default no hit", hit_cnt - h0, 0);
    bus_stop();
    wclk(H);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule